// File: doc/BRIEF.md
# Disk Request Port Controller

This block sits on a CPU's byte-wide I/O bus and collects the parameters of one sector transfer: a 16-bit DMA address, a memory bank for that address, a 16-bit sector number, a 16-bit track number and a drive index. Each parameter byte has its own write port. The parameters stay in place between transfers, so software only rewrites the fields that change. The request is always a whole 512-byte sector. Moving the data is the back end's job.

A transfer is started by one CPU read of one of two launch ports. One port means "read a sector into memory" and the other means "write a sector from memory". The launching read is stretched with a wait signal. During that time the block presents the packed request to a storage back end, holding `req_valid` until the back end pulses `rsp_ack` with a status byte. The stalled read then completes, and that status byte is its data: zero means success and any other value means an error.

The controller has three states. `ST_IDLE` goes to `ST_ISSUE` when a read of a launch port is seen. `ST_ISSUE` goes to `ST_DONE` when `rsp_ack` arrives. `ST_DONE` goes back to `ST_IDLE` once the CPU drops its read strobe. Every other input leaves the state unchanged. The parameter `BANK_EN` selects whether the bank port exists. With `BANK_EN` = 0 the bank is always 0.

Top module: `dskreq_ctrl`

## Requirements
- R1: After reset every parameter field, including the bank, is 0, `req_valid` is 0, `io_wait` is 0 and `io_rdata` is 0.
- R2: A write to port 0 sets bits 7:0 and a write to port 1 sets bits 15:8 of `req_dma_addr`, each without touching the other byte.
- R3: Ports 2 and 3 set the low and high bytes of `req_sector`. Ports 4 and 5 set the low and high bytes of `req_track`.
- R4: A write to port 6 sets `req_drive`.
- R5: With `BANK_EN` = 1 a write to port 7 sets `req_bank`. With `BANK_EN` = 0 `req_bank` stays 0 whatever is written to port 7.
- R6: A read of port 8 launches a request with `req_write` = 0 (sector read). A read of port 9 launches one with `req_write` = 1 (sector write).
- R7: `io_wait` is 1 combinationally in the cycle a launch read is first presented, and it stays 1 until the cycle after `rsp_ack`. From then on `io_rdata` carries the acknowledged status byte until the read strobe drops.
- R8: Each launch raises `req_valid` one cycle after the launch read is presented. `req_valid` stays high with unchanged fields until `rsp_ack`, falls in the next cycle, and does not rise again until a new launch.
- R9: Parameter fields keep their values across launches when their ports are not rewritten.
- R10: A write to a launch port changes nothing. A read of a port that is not a launch port returns 0 without asserting `io_wait` or starting a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_port | input | PORT_W | I/O port offset |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe, held by the CPU while io_wait is high |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (status after a launch) |
| io_wait | output | 1 | Stall for the current read |
| req_valid | output | 1 | Request to the back end is pending |
| req_write | output | 1 | 1 = sector write, 0 = sector read |
| req_dma_addr | output | 16 | DMA address |
| req_bank | output | 8 | DMA memory bank |
| req_sector | output | 16 | Sector number |
| req_track | output | 16 | Track number |
| req_drive | output | 8 | Drive index |
| rsp_ack | input | 1 | One-cycle acknowledge from the back end |
| rsp_status | input | 8 | Status byte, valid with rsp_ack |

## Verification
Random runs rewrite a random subset of the parameter bytes before each launch. This shows that each byte lands in its own field and that bytes left alone keep their values. Each launch uses a random direction, a random status (zero and nonzero) and an acknowledge delay of zero to three cycles. This separates a correctly held request and stall from one that drops early, repeats, or returns a stale status. Directed cases cover the reset values, a write to a launch port, a read of a plain parameter port, and a second instance with banking disabled. Together they separate ignored accesses and the bank variant from real launches.

// File: rtl/dskreq_pkg.sv
package dskreq_pkg;

    localparam int BYTE_W          = 8;
    localparam int NUM_PARAM_BYTES = 8;
    localparam int SECTOR_BYTES    = 512;

    localparam int OFS_DMA_LO   = 0;
    localparam int OFS_DMA_HI   = 1;
    localparam int OFS_SEC_LO   = 2;
    localparam int OFS_SEC_HI   = 3;
    localparam int OFS_TRK_LO   = 4;
    localparam int OFS_TRK_HI   = 5;
    localparam int OFS_DRIVE    = 6;
    localparam int OFS_BANK     = 7;
    localparam int OFS_GO_READ  = 8;
    localparam int OFS_GO_WRITE = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } dskreq_state_t;

    typedef struct packed {
        logic [15:0] dma_addr;
        logic [7:0]  bank;
        logic [15:0] sector;
        logic [15:0] track;
        logic [7:0]  drive;
    } dskreq_params_t;

endpackage

// File: rtl/dskreq_regfile.sv
module dskreq_regfile
    import dskreq_pkg::*;
#(
    parameter int PORT_W  = 4,
    parameter bit BANK_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_W-1:0]    io_port,
    input  logic                 io_wr,
    input  logic [BYTE_W-1:0]    io_wdata,
    output dskreq_params_t       params
);

    logic [BYTE_W-1:0] byte_q [NUM_PARAM_BYTES];

    for (genvar gi = 0; gi < NUM_PARAM_BYTES; gi++) begin : g_byte
        if (gi == OFS_BANK && !BANK_EN) begin : g_tied
            assign byte_q[gi] = '0;
        end else begin : g_reg
            logic [BYTE_W-1:0] q;
            logic              hit;
            assign hit = io_wr && (io_port == PORT_W'(gi));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= io_wdata;
            end
            assign byte_q[gi] = q;
        end
    end

    always_comb begin
        params.dma_addr = {byte_q[OFS_DMA_HI], byte_q[OFS_DMA_LO]};
        params.sector   = {byte_q[OFS_SEC_HI], byte_q[OFS_SEC_LO]};
        params.track    = {byte_q[OFS_TRK_HI], byte_q[OFS_TRK_LO]};
        params.drive    = byte_q[OFS_DRIVE];
        params.bank     = byte_q[OFS_BANK];
    end

    // R9
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(params));

    // R2
    dma_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == PORT_W'(OFS_DMA_LO)) |=>
            (params.dma_addr[7:0] == $past(io_wdata)) && $stable(params.dma_addr[15:8]));

endmodule

// File: rtl/dskreq_fsm.sv
module dskreq_fsm
    import dskreq_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] io_port,
    input  logic              io_rd,
    output logic              io_wait,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              req_valid,
    output logic              req_write,
    input  logic              rsp_ack,
    input  logic [BYTE_W-1:0] rsp_status
);

    dskreq_state_t     state_q, state_d;
    logic              dir_q;
    logic [BYTE_W-1:0] status_q;
    logic              go_rd, go_wr, go_any;

    assign go_rd  = io_rd && (io_port == PORT_W'(OFS_GO_READ));
    assign go_wr  = io_rd && (io_port == PORT_W'(OFS_GO_WRITE));
    assign go_any = go_rd || go_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_any)  state_d = ST_ISSUE;
            ST_ISSUE: if (rsp_ack) state_d = ST_DONE;
            ST_DONE:  if (!io_rd)  state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dir_q    <= 1'b0;
            status_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go_any) dir_q    <= go_wr;
            if (state_q == ST_ISSUE && rsp_ack) status_q <= rsp_status;
        end
    end

    always_comb begin
        req_valid = (state_q == ST_ISSUE);
        req_write = dir_q;
        io_wait   = (state_q == ST_ISSUE) || (state_q == ST_IDLE && go_any);
        io_rdata  = (state_q == ST_DONE) ? status_q : '0;
    end

    // R6
    launch_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go_wr) |=> req_valid && req_write);

    // R10
    plain_read_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && io_rd && !go_any) |-> !io_wait);

    // R8
    ack_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_ack) |=> !req_valid);

    // R7
    status_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_ack) |=> !io_wait && io_rdata == $past(rsp_status));

endmodule

// File: rtl/dskreq_ctrl.sv
module dskreq_ctrl
    import dskreq_pkg::*;
#(
    parameter int PORT_W  = 4,
    parameter bit BANK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] io_port,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_wait,
    output logic              req_valid,
    output logic              req_write,
    output logic [15:0]       req_dma_addr,
    output logic [7:0]        req_bank,
    output logic [15:0]       req_sector,
    output logic [15:0]       req_track,
    output logic [7:0]        req_drive,
    input  logic              rsp_ack,
    input  logic [7:0]        rsp_status
);

    dskreq_params_t params;

    dskreq_regfile #(.PORT_W(PORT_W), .BANK_EN(BANK_EN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_port  (io_port),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .params   (params)
    );

    dskreq_fsm #(.PORT_W(PORT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_port    (io_port),
        .io_rd      (io_rd),
        .io_wait    (io_wait),
        .io_rdata   (io_rdata),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .rsp_ack    (rsp_ack),
        .rsp_status (rsp_status)
    );

    assign req_dma_addr = params.dma_addr;
    assign req_bank     = params.bank;
    assign req_sector   = params.sector;
    assign req_track    = params.track;
    assign req_drive    = params.drive;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ack) |=> req_valid && $stable(params) && $stable(req_write));

    // R7
    wait_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> io_wait);

endmodule

// File: tb/dskreq_ctrl_test.sv
module dskreq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] io_port = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0, rsp_status = '0;
    logic       rsp_ack = 1'b0;

    logic [7:0]  io_rdata, req_bank, req_drive;
    logic        io_wait, req_valid, req_write;
    logic [15:0] req_dma_addr, req_sector, req_track;

    logic [7:0]  nb_rdata, nb_bank, nb_drive;
    logic        nb_wait, nb_valid, nb_write;
    logic [15:0] nb_addr, nb_sector, nb_track;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] exp_b [8];

    always #2 clk = ~clk;

    dskreq_ctrl #(.PORT_W(4), .BANK_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_wait(io_wait),
        .req_valid(req_valid), .req_write(req_write), .req_dma_addr(req_dma_addr),
        .req_bank(req_bank), .req_sector(req_sector), .req_track(req_track),
        .req_drive(req_drive), .rsp_ack(rsp_ack), .rsp_status(rsp_status));

    dskreq_ctrl #(.PORT_W(4), .BANK_EN(1'b0)) uut_nb (
        .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(nb_rdata), .io_wait(nb_wait),
        .req_valid(nb_valid), .req_write(nb_write), .req_dma_addr(nb_addr),
        .req_bank(nb_bank), .req_sector(nb_sector), .req_track(nb_track),
        .req_drive(nb_drive), .rsp_ack(rsp_ack), .rsp_status(rsp_status));

    function automatic logic [15:0] exp_addr();   return {exp_b[1], exp_b[0]}; endfunction
    function automatic logic [15:0] exp_sector(); return {exp_b[3], exp_b[2]}; endfunction
    function automatic logic [15:0] exp_track();  return {exp_b[5], exp_b[4]}; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_fields();
        chk("R2 dma_addr", 32'(req_dma_addr), 32'(exp_addr()));
        chk("R3 sector", 32'(req_sector), 32'(exp_sector()));
        chk("R3 track", 32'(req_track), 32'(exp_track()));
        chk("R4 drive", 32'(req_drive), 32'(exp_b[6]));
        chk("R5 bank", 32'(req_bank), 32'(exp_b[7]));
        chk("R5 bank disabled", 32'(nb_bank), 32'd0);
    endtask

    task automatic wr_port(input int p, input logic [7:0] d);
        @(negedge clk);
        io_port = 4'(p); io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (p < 8) exp_b[p] = d;
    endtask

    task automatic launch(input bit is_wr, input logic [7:0] status, input int delay);
        @(negedge clk);
        io_port = is_wr ? 4'd9 : 4'd8; io_rd = 1'b1;
        #1;
        chk("R7 wait at launch", 32'(io_wait), 32'd1);
        chk("R8 valid not yet", 32'(req_valid), 32'd0);
        @(negedge clk);
        chk("R8 valid raised", 32'(req_valid), 32'd1);
        chk("R6 direction", 32'(req_write), 32'(is_wr));
        chk("R7 wait held", 32'(io_wait), 32'd1);
        chk_fields();
        for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            chk("R8 valid held", 32'(req_valid), 32'd1);
            chk("R7 wait held", 32'(io_wait), 32'd1);
        end
        rsp_ack = 1'b1; rsp_status = status;
        @(negedge clk);
        rsp_ack = 1'b0; rsp_status = ~status;
        chk("R8 valid dropped", 32'(req_valid), 32'd0);
        chk("R7 wait released", 32'(io_wait), 32'd0);
        chk("R7 status", 32'(io_rdata), 32'(status));
        io_rd = 1'b0;
        @(negedge clk);
        chk("R8 no repeat", 32'(req_valid), 32'd0);
        chk("R7 rdata idle", 32'(io_rdata), 32'd0);
    endtask

    initial begin
        logic [15:0] keep_sec;
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) exp_b[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(req_valid), 32'd0);
        chk("R1 wait", 32'(io_wait), 32'd0);
        chk("R1 rdata", 32'(io_rdata), 32'd0);
        chk("R1 addr", 32'(req_dma_addr), 32'd0);
        chk("R1 bank", 32'(req_bank), 32'd0);
        chk("R1 sector", 32'(req_sector), 32'd0);
        chk("R1 track", 32'(req_track), 32'd0);
        chk("R1 drive", 32'(req_drive), 32'd0);
        launch(1'b0, 8'h00, 0);

        // directed field writes, R2 byte independence
        wr_port(0, 8'h34); wr_port(1, 8'hE0);
        wr_port(2, 8'h12); wr_port(3, 8'h00);
        wr_port(4, 8'h07); wr_port(5, 8'h01);
        wr_port(6, 8'h02); wr_port(7, 8'h01);
        chk_fields();
        wr_port(0, 8'hFF);
        chk("R2 hi kept", 32'(req_dma_addr), 32'h0000E0FF);
        launch(1'b1, 8'hFF, 2);

        // R10 write to launch ports ignored, plain read gives nothing
        wr_port(8, 8'hAA); wr_port(9, 8'h55);
        chk("R10 no request", 32'(req_valid), 32'd0);
        chk_fields();
        @(negedge clk);
        io_port = 4'd3; io_rd = 1'b1;
        #1;
        chk("R10 plain read no wait", 32'(io_wait), 32'd0);
        chk("R10 plain read data", 32'(io_rdata), 32'd0);
        @(negedge clk);
        chk("R10 plain read no request", 32'(req_valid), 32'd0);
        io_rd = 1'b0;

        // R9 retention across launches
        keep_sec = req_sector;
        launch(1'b0, 8'h01, 1);
        wr_port(6, 8'h03);
        launch(1'b1, 8'h00, 3);
        chk("R9 sector kept", 32'(req_sector), 32'(keep_sec));
        chk("R9 addr kept", 32'(req_dma_addr), 32'h0000E0FF);

        // random mix
        for (int it = 0; it < 40; it++) begin
            for (int p = 0; p < 8; p++)
                if ($urandom_range(1, 0) == 1) wr_port(p, 8'($urandom));
            chk_fields();
            launch(1'($urandom), ($urandom_range(2, 0) == 0) ? 8'h00 : 8'($urandom),
                   int'($urandom_range(3, 0)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule